// File: doc/BRIEF.md
# USB PHY Power-Up Sequencer

This block brings a combined USB2/USB3 PHY and its controller out of reset in a fixed order. A start command runs the whole bring-up. The PHY resets go active first and the controller resets follow. The block then selects the reference-clock path, lifts the PHY out of its low-power and test modes, and signals that power is stable. It then programs the Type-C mux and enables spread-spectrum clocking. After that it releases the PHY resets and, after timed settle intervals, the controller resets. It forces the VBUS-valid indications. It ends with a tuning step: a parameter word is loaded, and one PHY register is read, modified and written back.

The tuning access goes through a request/response port to an external control-register master. A request is offered with `cr_req_valid` and taken when `cr_req_ready` is high on the same clock edge. While the request waits, its direction, address and write data stay unchanged, so the master may stall it for any number of cycles. Responses arrive as single-cycle `cr_rsp_valid` pulses with no back-pressure. The status encoding is 0 for success, 1 for timeout and 2 (or 3) for failure. Only one request is outstanding at a time.

A shutdown command puts the PHY back into reset. If the pad clock path is selected, shutdown also gates the PHY reference clock off. The settle intervals are counted in system clocks as `CLK_MHZ * DELAY_US`.

Top module: `usbphy_pwrseq`

## Requirements
- R1: Out of reset, all four resets are asserted (low) and `iddq_en`, `test_pwrdn` and `tc_low_pwr` are 1. `seq_done`, `seq_err`, `ssc_en`, the power, clock, mux, VBUS fields and `eye_word` are 0.
- R2: `start` is taken in the idle, done or error state. The clock edge that samples it drives `phy3_rst_n` and `usb2_por_n` low and clears `seq_done` and `seq_err`. Exactly one cycle later, `ctrl_rst_n` and `aux_rst_n` go low.
- R3: Two cycles after the start edge, the block samples `refclk_pad_sts`.
  - If it is 0, the block drives `refclk_sel`=3 and `refclk_pad_sel`=0 and leaves `refclk_gate_en` unchanged.
  - If it is 1, the block drives `refclk_sel`=2, `refclk_pad_sel`=1 and `refclk_gate_en`=1.
- R4: The power steps come after the clock step, in this order:
  - `iddq_en` clears one cycle after the clock step.
  - `test_pwrdn` clears one cycle after that.
  - `ana_pwr_en`, `pcs_pwr_stable` and `pma_pwr_stable` rise together one cycle after that.
- R5: The Type-C mux steps follow, one per cycle, in this order:
  - `tc_irq_clr` pulses all-ones for one cycle.
  - `tc_irq_en` becomes 2'b11 (bit 1 timeout, bit 0 acknowledge).
  - `tc_role_sel` becomes 1.
  - `tc_mux_ctrl` becomes 1 with `tc_mux_valid`=1 and `tc_low_pwr`=0.
  - `tc_vbus_ovr` and `tc_pwrpres_ovr` both become 2'b11.
- R6: `ssc_en` rises one cycle after the override step. `phy3_rst_n` and `usb2_por_n` are released one cycle after `ssc_en` rises.
- R7: With WAIT = `CLK_MHZ*DELAY_US`, the timed steps are spaced WAIT+1 cycles apart:
  - `ctrl_rst_n` and `aux_rst_n` rise WAIT+1 cycles after the PHY reset release.
  - `vbus3_valid`, `vbus3_valid_sel`, `vbus2_valid` and `vbus2_valid_sel` rise WAIT+1 cycles after that.
  - `eye_word` takes `eye_param` WAIT+1 cycles after that.
- R8: Tuning reads address 0xF. It writes back the read value ORed with bit 9 and with `boost_lvl` shifted to start at bit 6. A successful write response sets `seq_done`.
- R9: A read that returns timeout is retried, up to 3 reads in total. A third timeout sets `seq_err` and no write is issued.
- R10: A failure status on the read or the write sets `seq_err` at once, with no retry.
- R11: `shutdown` in the idle, done or error state drives `phy3_rst_n` and `usb2_por_n` low and clears `seq_done`. It also clears `refclk_gate_en` when `refclk_pad_sel` is 1.
- R12: While `cr_req_valid` is high and `cr_req_ready` is low, the request stays valid with `cr_req_write`, `cr_req_addr` and `cr_req_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the bring-up sequence |
| shutdown | input | 1 | Put the PHY back into reset |
| refclk_pad_sts | input | 1 | Clock-source status: 1 selects the pad path |
| eye_param | input | EYE_W | Eye-diagram parameter word |
| boost_lvl | input | LVL_W | Transmit boost level |
| phy3_rst_n | output | 1 | USB3 PHY reset, active low |
| usb2_por_n | output | 1 | USB2 PHY power-on reset, active low |
| ctrl_rst_n | output | 1 | Controller reset, active low |
| aux_rst_n | output | 1 | Auxiliary-domain reset, active low |
| refclk_pad_sel | output | 1 | Reference clock taken from the pad |
| refclk_sel | output | 2 | USB2 reference select (3 internal, 2 pad) |
| refclk_gate_en | output | 1 | PHY reference clock gate enable |
| iddq_en | output | 1 | USB2 IDDQ low-power mode |
| test_pwrdn | output | 1 | USB3 test power-down |
| ana_pwr_en | output | 1 | Analog power enable |
| pcs_pwr_stable | output | 1 | PCS power stable |
| pma_pwr_stable | output | 1 | PMA power stable |
| ssc_en | output | 1 | Spread-spectrum clocking enable |
| tc_irq_clr | output | IRQ_W | Type-C interrupt status clear pulse |
| tc_irq_en | output | 2 | Type-C interrupt enables {timeout, ack} |
| tc_role_sel | output | 1 | Host/device role select |
| tc_mux_ctrl | output | 2 | Type-C mux control value |
| tc_mux_valid | output | 1 | Mux control valid |
| tc_low_pwr | output | 1 | Mux low-power enable |
| tc_vbus_ovr | output | 2 | VBUS-valid override |
| tc_pwrpres_ovr | output | 2 | Power-present override |
| vbus3_valid | output | 1 | Forced USB3 VBUS valid |
| vbus3_valid_sel | output | 1 | USB3 VBUS-valid source select |
| vbus2_valid | output | 1 | Forced USB2 VBUS valid |
| vbus2_valid_sel | output | 1 | USB2 VBUS-valid source select |
| eye_word | output | EYE_W | Applied eye-diagram parameter |
| cr_req_valid | output | 1 | Control-register request valid |
| cr_req_ready | input | 1 | Request accepted by the master |
| cr_req_write | output | 1 | 1 = write, 0 = read |
| cr_req_addr | output | CR_AW | Register address |
| cr_req_wdata | output | CR_DW | Write data |
| cr_rsp_valid | input | 1 | Response pulse |
| cr_rsp_status | input | 2 | 0 ok, 1 timeout, 2/3 failure |
| cr_rsp_rdata | input | CR_DW | Read data |
| seq_done | output | 1 | Sequence completed |
| seq_err | output | 1 | Sequence aborted |

## Verification
Counting from the edge that samples `start`, the fixed steps are due as follows:
- The PHY resets change at that edge, and the controller resets change one cycle later.
- The clock step comes at +2 and the power steps at +3 to +5.
- The Type-C steps come at +6 to +10, SSC at +11 and the PHY reset release at +12.
- Each timed step follows the previous one by WAIT+1 cycles.

The bench advances one falling edge per step. At each step it checks the value due after the preceding rising edge. On the last cycle before each timed step, it also checks that the step has not yet happened. Tuning completion depends on the stalls and latency of the modelled master. For that step the bench polls for `seq_done` or `seq_err` within a bound, then compares the read and write counts and the written word.

// File: rtl/usbphy_pwrseq_pkg.sv
package usbphy_pwrseq_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_CTLRST, S_CLK, S_IDDQ, S_TPD, S_PWR,
    S_TCCLR, S_TCIEN, S_TCROLE, S_TCMUX, S_TCVBUS,
    S_SSC, S_PHYREL, S_W1, S_CTLREL, S_W2, S_VBUS, S_W3,
    S_EYE, S_TUNE, S_DONE, S_ERR
  } seq_state_e;

  typedef enum logic [2:0] {
    T_IDLE, T_RDREQ, T_RDWAIT, T_WRREQ, T_WRWAIT
  } tune_state_e;

  localparam logic [1:0] CR_OK      = 2'd0;
  localparam logic [1:0] CR_TIMEOUT = 2'd1;

endpackage

// File: rtl/usbphy_pwrseq_timer.sv
module usbphy_pwrseq_timer #(
  parameter int CYCLES = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || expire) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/usbphy_pwrseq_tune.sv
module usbphy_pwrseq_tune
  import usbphy_pwrseq_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int TRIES   = 3,
  parameter int ADDR    = 15,
  parameter int EN_BIT  = 9,
  parameter int LVL_LSB = 6,
  parameter int LVL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LVL_W-1:0] boost,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic [DW-1:0]    req_wdata,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_status,
  input  logic [DW-1:0]    rsp_rdata,
  output logic             done,
  output logic             fail
);
  localparam int TW = $clog2(TRIES + 1);
  localparam logic [DW-1:0] EN_MASK = DW'(1) << EN_BIT;

  tune_state_e   st_q;
  logic [TW-1:0] tries_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] lvl_field;

  assign lvl_field = {{(DW-LVL_W){1'b0}}, boost} << LVL_LSB;
  assign req_valid = (st_q == T_RDREQ) || (st_q == T_WRREQ);
  assign req_write = (st_q == T_WRREQ);
  assign req_addr  = AW'(ADDR);
  assign req_wdata = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= T_IDLE;
      tries_q <= '0;
      wdata_q <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (st_q)
        T_IDLE: if (go) begin
          tries_q <= '0;
          st_q    <= T_RDREQ;
        end
        T_RDREQ: if (req_ready) st_q <= T_RDWAIT;
        T_RDWAIT: if (rsp_valid) begin
          if (rsp_status == CR_OK) begin
            wdata_q <= rsp_rdata | EN_MASK | lvl_field;
            st_q    <= T_WRREQ;
          end else if (rsp_status == CR_TIMEOUT && tries_q != TW'(TRIES - 1)) begin
            tries_q <= tries_q + 1'b1;
            st_q    <= T_RDREQ;
          end else begin
            fail <= 1'b1;
            st_q <= T_IDLE;
          end
        end
        T_WRREQ: if (req_ready) st_q <= T_WRWAIT;
        T_WRWAIT: if (rsp_valid) begin
          if (rsp_status == CR_OK) done <= 1'b1;
          else                     fail <= 1'b1;
          st_q <= T_IDLE;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usbphy_pwrseq.sv
module usbphy_pwrseq
  import usbphy_pwrseq_pkg::*;
#(
  parameter int CLK_MHZ    = 125,
  parameter int DELAY_US   = 100,
  parameter int EYE_W      = 24,
  parameter int LVL_W      = 3,
  parameter int CR_AW      = 16,
  parameter int CR_DW      = 16,
  parameter int IRQ_W      = 16,
  parameter int TUNE_TRIES = 3,
  parameter int TUNE_ADDR  = 15,
  parameter int LVL_EN_BIT = 9,
  parameter int LVL_LSB    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             shutdown,
  input  logic             refclk_pad_sts,
  input  logic [EYE_W-1:0] eye_param,
  input  logic [LVL_W-1:0] boost_lvl,
  output logic             phy3_rst_n,
  output logic             usb2_por_n,
  output logic             ctrl_rst_n,
  output logic             aux_rst_n,
  output logic             refclk_pad_sel,
  output logic [1:0]       refclk_sel,
  output logic             refclk_gate_en,
  output logic             iddq_en,
  output logic             test_pwrdn,
  output logic             ana_pwr_en,
  output logic             pcs_pwr_stable,
  output logic             pma_pwr_stable,
  output logic             ssc_en,
  output logic [IRQ_W-1:0] tc_irq_clr,
  output logic [1:0]       tc_irq_en,
  output logic             tc_role_sel,
  output logic [1:0]       tc_mux_ctrl,
  output logic             tc_mux_valid,
  output logic             tc_low_pwr,
  output logic [1:0]       tc_vbus_ovr,
  output logic [1:0]       tc_pwrpres_ovr,
  output logic             vbus3_valid,
  output logic             vbus3_valid_sel,
  output logic             vbus2_valid,
  output logic             vbus2_valid_sel,
  output logic [EYE_W-1:0] eye_word,
  output logic             cr_req_valid,
  input  logic             cr_req_ready,
  output logic             cr_req_write,
  output logic [CR_AW-1:0] cr_req_addr,
  output logic [CR_DW-1:0] cr_req_wdata,
  input  logic             cr_rsp_valid,
  input  logic [1:0]       cr_rsp_status,
  input  logic [CR_DW-1:0] cr_rsp_rdata,
  output logic             seq_done,
  output logic             seq_err
);
  localparam int         WAIT_CYC    = CLK_MHZ * DELAY_US;
  localparam logic [1:0] SEL_INTERNAL = 2'd3;
  localparam logic [1:0] SEL_PAD      = 2'd2;
  localparam logic [1:0] MUX_USB_ONLY = 2'd1;

  seq_state_e st_q;
  logic       wait_run, wait_exp;
  logic       tune_go_q, tune_done, tune_fail;
  logic       accept_cmd;

  assign wait_run   = (st_q == S_W1) || (st_q == S_W2) || (st_q == S_W3);
  assign accept_cmd = (st_q == S_IDLE) || (st_q == S_DONE) || (st_q == S_ERR);

  usbphy_pwrseq_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(wait_run), .expire(wait_exp)
  );

  usbphy_pwrseq_tune #(
    .AW(CR_AW), .DW(CR_DW), .TRIES(TUNE_TRIES), .ADDR(TUNE_ADDR),
    .EN_BIT(LVL_EN_BIT), .LVL_LSB(LVL_LSB), .LVL_W(LVL_W)
  ) u_tune (
    .clk(clk), .rst_n(rst_n), .go(tune_go_q), .boost(boost_lvl),
    .req_valid(cr_req_valid), .req_ready(cr_req_ready), .req_write(cr_req_write),
    .req_addr(cr_req_addr), .req_wdata(cr_req_wdata),
    .rsp_valid(cr_rsp_valid), .rsp_status(cr_rsp_status), .rsp_rdata(cr_rsp_rdata),
    .done(tune_done), .fail(tune_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q            <= S_IDLE;
      phy3_rst_n      <= 1'b0;
      usb2_por_n      <= 1'b0;
      ctrl_rst_n      <= 1'b0;
      aux_rst_n       <= 1'b0;
      refclk_pad_sel  <= 1'b0;
      refclk_sel      <= 2'd0;
      refclk_gate_en  <= 1'b0;
      iddq_en         <= 1'b1;
      test_pwrdn      <= 1'b1;
      ana_pwr_en      <= 1'b0;
      pcs_pwr_stable  <= 1'b0;
      pma_pwr_stable  <= 1'b0;
      ssc_en          <= 1'b0;
      tc_irq_clr      <= '0;
      tc_irq_en       <= 2'd0;
      tc_role_sel     <= 1'b0;
      tc_mux_ctrl     <= 2'd0;
      tc_mux_valid    <= 1'b0;
      tc_low_pwr      <= 1'b1;
      tc_vbus_ovr     <= 2'd0;
      tc_pwrpres_ovr  <= 2'd0;
      vbus3_valid     <= 1'b0;
      vbus3_valid_sel <= 1'b0;
      vbus2_valid     <= 1'b0;
      vbus2_valid_sel <= 1'b0;
      eye_word        <= '0;
      tune_go_q       <= 1'b0;
      seq_done        <= 1'b0;
      seq_err         <= 1'b0;
    end else begin
      tc_irq_clr <= '0;
      tune_go_q  <= 1'b0;
      if (accept_cmd && start) begin
        phy3_rst_n <= 1'b0;
        usb2_por_n <= 1'b0;
        seq_done   <= 1'b0;
        seq_err    <= 1'b0;
        st_q       <= S_CTLRST;
      end else if (accept_cmd && shutdown) begin
        phy3_rst_n <= 1'b0;
        usb2_por_n <= 1'b0;
        if (refclk_pad_sel) refclk_gate_en <= 1'b0;
        seq_done   <= 1'b0;
        st_q       <= S_IDLE;
      end else begin
        case (st_q)
          S_CTLRST: begin
            ctrl_rst_n <= 1'b0;
            aux_rst_n  <= 1'b0;
            st_q       <= S_CLK;
          end
          S_CLK: begin
            if (refclk_pad_sts) begin
              refclk_pad_sel <= 1'b1;
              refclk_sel     <= SEL_PAD;
              refclk_gate_en <= 1'b1;
            end else begin
              refclk_pad_sel <= 1'b0;
              refclk_sel     <= SEL_INTERNAL;
            end
            st_q <= S_IDDQ;
          end
          S_IDDQ: begin iddq_en <= 1'b0; st_q <= S_TPD; end
          S_TPD:  begin test_pwrdn <= 1'b0; st_q <= S_PWR; end
          S_PWR: begin
            ana_pwr_en     <= 1'b1;
            pcs_pwr_stable <= 1'b1;
            pma_pwr_stable <= 1'b1;
            st_q           <= S_TCCLR;
          end
          S_TCCLR:  begin tc_irq_clr <= '1; st_q <= S_TCIEN; end
          S_TCIEN:  begin tc_irq_en <= 2'b11; st_q <= S_TCROLE; end
          S_TCROLE: begin tc_role_sel <= 1'b1; st_q <= S_TCMUX; end
          S_TCMUX: begin
            tc_mux_ctrl  <= MUX_USB_ONLY;
            tc_mux_valid <= 1'b1;
            tc_low_pwr   <= 1'b0;
            st_q         <= S_TCVBUS;
          end
          S_TCVBUS: begin
            tc_vbus_ovr    <= 2'b11;
            tc_pwrpres_ovr <= 2'b11;
            st_q           <= S_SSC;
          end
          S_SSC: begin ssc_en <= 1'b1; st_q <= S_PHYREL; end
          S_PHYREL: begin
            phy3_rst_n <= 1'b1;
            usb2_por_n <= 1'b1;
            st_q       <= S_W1;
          end
          S_W1: if (wait_exp) st_q <= S_CTLREL;
          S_CTLREL: begin
            ctrl_rst_n <= 1'b1;
            aux_rst_n  <= 1'b1;
            st_q       <= S_W2;
          end
          S_W2: if (wait_exp) st_q <= S_VBUS;
          S_VBUS: begin
            vbus3_valid     <= 1'b1;
            vbus3_valid_sel <= 1'b1;
            vbus2_valid     <= 1'b1;
            vbus2_valid_sel <= 1'b1;
            st_q            <= S_W3;
          end
          S_W3: if (wait_exp) st_q <= S_EYE;
          S_EYE: begin
            eye_word  <= eye_param;
            tune_go_q <= 1'b1;
            st_q      <= S_TUNE;
          end
          S_TUNE: begin
            if (tune_done) begin
              seq_done <= 1'b1;
              st_q     <= S_DONE;
            end else if (tune_fail) begin
              seq_err <= 1'b1;
              st_q    <= S_ERR;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/usbphy_pwrseq_chk.sv
module usbphy_pwrseq_chk #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int IRQ_W = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phy3_rst_n,
  input logic          usb2_por_n,
  input logic          ctrl_rst_n,
  input logic          aux_rst_n,
  input logic          ssc_en,
  input logic [IRQ_W-1:0] tc_irq_clr,
  input logic          vbus3_valid,
  input logic          vbus2_valid,
  input logic          cr_req_valid,
  input logic          cr_req_ready,
  input logic          cr_req_write,
  input logic [AW-1:0] cr_req_addr,
  input logic [DW-1:0] cr_req_wdata,
  input logic          seq_done,
  input logic          seq_err
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_req_valid && !cr_req_ready |=> cr_req_valid && $stable(cr_req_write)
      && $stable(cr_req_addr) && $stable(cr_req_wdata));

  // R2
  ctl_after_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rst_n) |-> !phy3_rst_n && !usb2_por_n);

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_irq_clr != '0) |=> (tc_irq_clr == '0));

  // R6
  ssc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy3_rst_n) |-> $past(ssc_en));

  // R7
  ctl_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_n) |-> phy3_rst_n && usb2_por_n && aux_rst_n);

  // R8
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> ctrl_rst_n && vbus3_valid && vbus2_valid);

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_done && seq_err));
endmodule

bind usbphy_pwrseq usbphy_pwrseq_chk #(.AW(CR_AW), .DW(CR_DW), .IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phy3_rst_n(phy3_rst_n), .usb2_por_n(usb2_por_n),
  .ctrl_rst_n(ctrl_rst_n), .aux_rst_n(aux_rst_n), .ssc_en(ssc_en),
  .tc_irq_clr(tc_irq_clr), .vbus3_valid(vbus3_valid), .vbus2_valid(vbus2_valid),
  .cr_req_valid(cr_req_valid), .cr_req_ready(cr_req_ready), .cr_req_write(cr_req_write),
  .cr_req_addr(cr_req_addr), .cr_req_wdata(cr_req_wdata),
  .seq_done(seq_done), .seq_err(seq_err)
);

// File: tb/usbphy_pwrseq_bench.sv
module usbphy_pwrseq_bench;
  localparam int CLK_MHZ  = 125;
  localparam int DELAY_US = 2;
  localparam int W        = CLK_MHZ * DELAY_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0, shutdown = 1'b0, refclk_pad_sts = 1'b0;
  logic [23:0] eye_param = '0;
  logic [2:0]  boost_lvl = '0;
  logic phy3_rst_n, usb2_por_n, ctrl_rst_n, aux_rst_n, refclk_pad_sel, refclk_gate_en;
  logic [1:0] refclk_sel, tc_irq_en, tc_mux_ctrl, tc_vbus_ovr, tc_pwrpres_ovr;
  logic iddq_en, test_pwrdn, ana_pwr_en, pcs_pwr_stable, pma_pwr_stable, ssc_en;
  logic [15:0] tc_irq_clr;
  logic tc_role_sel, tc_mux_valid, tc_low_pwr;
  logic vbus3_valid, vbus3_valid_sel, vbus2_valid, vbus2_valid_sel;
  logic [23:0] eye_word;
  logic cr_req_valid, cr_req_ready, cr_req_write;
  logic [15:0] cr_req_addr, cr_req_wdata;
  logic cr_rsp_valid = 1'b0;
  logic [1:0] cr_rsp_status = 2'd0;
  logic [15:0] cr_rsp_rdata = '0;
  logic seq_done, seq_err;

  usbphy_pwrseq #(.CLK_MHZ(CLK_MHZ), .DELAY_US(DELAY_US)) u_usbphy_pwrseq (
    .clk(clk), .rst_n(rst_n), .start(start), .shutdown(shutdown),
    .refclk_pad_sts(refclk_pad_sts), .eye_param(eye_param), .boost_lvl(boost_lvl),
    .phy3_rst_n(phy3_rst_n), .usb2_por_n(usb2_por_n), .ctrl_rst_n(ctrl_rst_n),
    .aux_rst_n(aux_rst_n), .refclk_pad_sel(refclk_pad_sel), .refclk_sel(refclk_sel),
    .refclk_gate_en(refclk_gate_en), .iddq_en(iddq_en), .test_pwrdn(test_pwrdn),
    .ana_pwr_en(ana_pwr_en), .pcs_pwr_stable(pcs_pwr_stable), .pma_pwr_stable(pma_pwr_stable),
    .ssc_en(ssc_en), .tc_irq_clr(tc_irq_clr), .tc_irq_en(tc_irq_en), .tc_role_sel(tc_role_sel),
    .tc_mux_ctrl(tc_mux_ctrl), .tc_mux_valid(tc_mux_valid), .tc_low_pwr(tc_low_pwr),
    .tc_vbus_ovr(tc_vbus_ovr), .tc_pwrpres_ovr(tc_pwrpres_ovr),
    .vbus3_valid(vbus3_valid), .vbus3_valid_sel(vbus3_valid_sel),
    .vbus2_valid(vbus2_valid), .vbus2_valid_sel(vbus2_valid_sel), .eye_word(eye_word),
    .cr_req_valid(cr_req_valid), .cr_req_ready(cr_req_ready), .cr_req_write(cr_req_write),
    .cr_req_addr(cr_req_addr), .cr_req_wdata(cr_req_wdata), .cr_rsp_valid(cr_rsp_valid),
    .cr_rsp_status(cr_rsp_status), .cr_rsp_rdata(cr_rsp_rdata),
    .seq_done(seq_done), .seq_err(seq_err)
  );

  // control-register master model
  int          cfg_timeouts = 0;
  logic        cfg_rderr = 1'b0, cfg_wrerr = 1'b0;
  logic [15:0] cfg_rdval = '0;
  int          rd_base = 0;
  int          rd_cnt = 0, wr_cnt = 0, viol = 0, pend = 0;
  logic [15:0] last_wdata = '0, last_addr = '0, pend_data = '0;
  logic [1:0]  pend_st = '0, rdy_phase = '0;
  logic        hold_q = 1'b0, hold_wr = 1'b0;
  logic [15:0] hold_addr = '0, hold_data = '0;

  assign cr_req_ready = (rdy_phase == 2'b11);

  always @(posedge clk) begin
    rdy_phase    <= rdy_phase + 2'd1;
    cr_rsp_valid <= 1'b0;
    if (hold_q && (!cr_req_valid || cr_req_write != hold_wr ||
                   cr_req_addr != hold_addr || cr_req_wdata != hold_data))
      viol <= viol + 1;
    hold_q    <= cr_req_valid && !cr_req_ready;
    hold_wr   <= cr_req_write;
    hold_addr <= cr_req_addr;
    hold_data <= cr_req_wdata;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        cr_rsp_valid  <= 1'b1;
        cr_rsp_status <= pend_st;
        cr_rsp_rdata  <= pend_data;
      end
    end
    if (cr_req_valid && cr_req_ready) begin
      pend      <= 3;
      last_addr <= cr_req_addr;
      if (cr_req_write) begin
        wr_cnt     <= wr_cnt + 1;
        last_wdata <= cr_req_wdata;
        pend_st    <= cfg_wrerr ? 2'd2 : 2'd0;
      end else begin
        rd_cnt    <= rd_cnt + 1;
        pend_data <= cfg_rdval;
        if ((rd_cnt - rd_base) < cfg_timeouts) pend_st <= 2'd1;
        else if (cfg_rderr)                   pend_st <= 2'd2;
        else                                  pend_st <= 2'd0;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 resets", {phy3_rst_n, usb2_por_n, ctrl_rst_n, aux_rst_n}, 4'b0000);
    chk("R1 low-power", {iddq_en, test_pwrdn, tc_low_pwr}, 3'b111);
    chk("R1 flags", {seq_done, seq_err, ssc_en, ana_pwr_en, pcs_pwr_stable, pma_pwr_stable}, 6'd0);
    chk("R1 clock", {refclk_pad_sel, refclk_sel, refclk_gate_en}, 4'd0);
    chk("R1 mux", {tc_irq_en, tc_role_sel, tc_mux_ctrl, tc_mux_valid, tc_vbus_ovr, tc_pwrpres_ovr}, 12'd0);
    chk("R1 vbus eye", {vbus3_valid, vbus3_valid_sel, vbus2_valid, vbus2_valid_sel, eye_word}, 28'd0);
  endtask

  // One full bring-up, stepped edge by edge from the start edge.
  task automatic run_init(input logic sts, input logic [2:0] boost, input logic [23:0] eye,
                          input int touts, input logic rderr, input logic wrerr,
                          input logic [15:0] rdval, input logic exp_ok,
                          input int exp_rd, input int exp_wr);
    logic fresh, pre_ctl, pre_gate;
    int rd0, wr0;
    cfg_timeouts = touts; cfg_rderr = rderr; cfg_wrerr = wrerr; cfg_rdval = rdval;
    rd_base = rd_cnt; rd0 = rd_cnt; wr0 = wr_cnt;
    fresh = !vbus3_valid; pre_ctl = ctrl_rst_n; pre_gate = refclk_gate_en;
    start = 1'b1; refclk_pad_sts = sts; boost_lvl = boost; eye_param = eye;
    tick(); start = 1'b0;
    // step 0
    chk("R2 phy resets low", {phy3_rst_n, usb2_por_n}, 2'b00);
    chk("R2 ctrl reset not yet", ctrl_rst_n, pre_ctl);
    chk("R2 flags cleared", {seq_done, seq_err}, 2'b00);
    tick();
    chk("R2 ctrl/aux low", {ctrl_rst_n, aux_rst_n}, 2'b00);
    tick();
    if (sts) chk("R3 pad path", {refclk_pad_sel, refclk_sel, refclk_gate_en}, 4'b1101);
    else     chk("R3 internal path", {refclk_pad_sel, refclk_sel, refclk_gate_en}, {3'b011, pre_gate});
    if (fresh) chk("R4 iddq still set", iddq_en, 1'b1);
    tick();
    chk("R4 iddq cleared", iddq_en, 1'b0);
    if (fresh) chk("R4 test pd still set", test_pwrdn, 1'b1);
    tick();
    chk("R4 test pd cleared", test_pwrdn, 1'b0);
    if (fresh) chk("R4 power not yet", {ana_pwr_en, pcs_pwr_stable, pma_pwr_stable}, 3'b000);
    tick();
    chk("R4 power stable", {ana_pwr_en, pcs_pwr_stable, pma_pwr_stable}, 3'b111);
    tick();
    chk("R5 irq clear pulse", tc_irq_clr, 16'hFFFF);
    tick();
    chk("R5 irq clear ends", tc_irq_clr, 16'h0000);
    chk("R5 irq enables", tc_irq_en, 2'b11);
    tick();
    chk("R5 role", tc_role_sel, 1'b1);
    tick();
    chk("R5 mux", {tc_mux_ctrl, tc_mux_valid, tc_low_pwr}, 4'b0110);
    tick();
    chk("R5 overrides", {tc_vbus_ovr, tc_pwrpres_ovr}, 4'b1111);
    tick();
    chk("R6 ssc on", ssc_en, 1'b1);
    chk("R6 phy still in reset", {phy3_rst_n, usb2_por_n}, 2'b00);
    tick();
    chk("R6 phy released", {phy3_rst_n, usb2_por_n}, 2'b11);
    repeat (W) tick();
    chk("R7 ctrl not yet", ctrl_rst_n, 1'b0);
    tick();
    chk("R7 ctrl released", {ctrl_rst_n, aux_rst_n}, 2'b11);
    repeat (W) tick();
    if (fresh) chk("R7 vbus not yet", vbus3_valid, 1'b0);
    tick();
    chk("R7 vbus forced", {vbus3_valid, vbus3_valid_sel, vbus2_valid, vbus2_valid_sel}, 4'b1111);
    repeat (W) tick();
    chk("R7 eye not yet", (eye_word != eye), 1'b1);
    tick();
    chk("R8 eye word", eye_word, eye);
    for (int i = 0; i < 400 && !(seq_done || seq_err); i++) tick();
    chk(exp_ok ? "R8 done" : "R10 err outcome", {seq_done, seq_err}, {exp_ok, !exp_ok});
    chk(touts >= 3 ? "R9 read count" : "R10 read count", rd_cnt - rd0, exp_rd);
    chk("R9 write count", wr_cnt - wr0, exp_wr);
    if (exp_wr > 0) begin
      chk("R8 write address", last_addr, 16'h000F);
      chk("R8 write data", last_wdata, rdval | 16'h0200 | ({13'd0, boost} << 6));
    end
  endtask

  task automatic t_shutdown(input logic exp_gate, input string tag);
    shutdown = 1'b1;
    tick(); shutdown = 1'b0;
    chk({tag, " phy resets"}, {phy3_rst_n, usb2_por_n}, 2'b00);
    chk({tag, " gate"}, refclk_gate_en, exp_gate);
    chk({tag, " done cleared"}, seq_done, 1'b0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    // R8: internal path, default tuning values, clean response
    run_init(1'b0, 3'd5, 24'hFDFEE4, 0, 1'b0, 1'b0, 16'h0021, 1'b1, 1, 1);
    // R11: internal path keeps the gate off
    t_shutdown(1'b0, "R11 internal");
    // R9: pad path, two timeouts then success
    run_init(1'b1, 3'd3, 24'h123456, 2, 1'b0, 1'b0, 16'h8001, 1'b1, 3, 1);
    // R9: re-init from done, three timeouts abort
    run_init(1'b1, 3'd5, 24'h0A0B0C, 3, 1'b0, 1'b0, 16'h0000, 1'b0, 3, 0);
    // R11: pad path gates the clock off
    t_shutdown(1'b0, "R11 pad");
    // R10: read failure, no retry
    run_init(1'b0, 3'd1, 24'h00BEEF, 0, 1'b1, 1'b0, 16'h0004, 1'b0, 1, 0);
    // R10: write failure
    run_init(1'b0, 3'd7, 24'h777777, 0, 1'b0, 1'b1, 16'h0010, 1'b0, 1, 1);
    chk("R12 request hold violations", viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule